// File: doc/BRIEF.md
# External Clock Bypass Request Controller

This block sits inside a clock manager. It turns two software selections and two life-cycle control words into three clock-bypass requests: one for the IO clock, one for all clocks, and one high-speed select. Every input and output is a 4-bit redundant boolean code. Only one exact code means "asserted". Every other code, including a corrupted one, is treated as deasserted. On the output side the block drives only the two strict codes.

The life-cycle bypass request drives the IO-clock bypass request alone. The all-clocks request needs two things at once: the software external-clock select must be True, and the life-cycle debug enable must be On. The high-speed select also needs the software high-speed select to be True. Each decoded enable first passes a synchronizer flop. It then reaches an output register that holds the multi-bit code. So every output follows its enable two clock edges later, which is inside the allowed window of one to three cycles.

Top module: `clkbyp_ctrl`

## Requirements
- R1: While the active-low reset is held low, all three outputs drive the False code 4'h9.
- R2: When the life-cycle bypass request input equals the On code 4'hA, the IO-clock bypass output drives the True code 4'h6.
- R3: When the life-cycle bypass request input holds any code other than 4'hA, the IO-clock bypass output returns to 4'h9.
- R4: The all-clocks bypass output is 4'h6 exactly when the external-clock select equals 4'h6 and the debug enable equals 4'hA. Otherwise it is 4'h9.
- R5: The high-speed select output is 4'h6 exactly when the external-clock select equals 4'h6, the high-speed select equals 4'h6 and the debug enable equals 4'hA. Otherwise it is 4'h9.
- R6: Any input code other than the exact asserted code counts as deasserted. This includes 4'h9, 4'h5, 4'h0, 4'hF and every other value.
- R7: Every output is always either 4'h6 or 4'h9.
- R8: Each output reflects the inputs present two clock edges earlier. An output does not change on the first edge after its input changes.
- R9: Whenever the high-speed select output is 4'h6, the all-clocks bypass output is also 4'h6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_ext_sel | input | 4 | Software external-clock select, 4'h6 = True |
| sw_fast_sel | input | 4 | Software high-speed select, 4'h6 = True |
| lc_dbg_en | input | 4 | Life-cycle debug enable, 4'hA = On |
| lc_byp_req | input | 4 | Life-cycle clock-bypass request, 4'hA = On |
| io_byp_req | output | 4 | IO-clock bypass request |
| all_byp_req | output | 4 | All-clocks bypass request |
| fast_sel | output | 4 | High-speed select |

## Verification
The latency assertions assume that input codes are sampled cleanly on the clock. They compare each output with the decoded enable from exactly two edges earlier. For that reason they wait until two clock edges have passed since reset. The bench drives every input on the falling edge, so no input changes near a rising edge. Its stimulus mixes exact asserted codes, the strict deasserted codes and arbitrary 4-bit values. This keeps both enabled and invalid-code cases frequent.

// File: rtl/clkbyp_pkg.sv
package clkbyp_pkg;
  localparam int CodeW = 4;
  typedef logic [CodeW-1:0] code_t;

  localparam code_t MB_TRUE  = 4'h6;
  localparam code_t MB_FALSE = 4'h9;
  localparam code_t LC_ON    = 4'hA;

  // lane order for the request vectors
  localparam int LANE_IO   = 0;
  localparam int LANE_ALL  = 1;
  localparam int LANE_FAST = 2;
  localparam int NumLanes  = 3;

  function automatic logic mb_is_true(code_t v);
    return v == MB_TRUE;
  endfunction

  function automatic logic lc_is_on(code_t v);
    return v == LC_ON;
  endfunction

  function automatic code_t mb_encode(logic b);
    return b ? MB_TRUE : MB_FALSE;
  endfunction

  function automatic logic code_is_strict(code_t v);
    return (v == MB_TRUE) || (v == MB_FALSE);
  endfunction
endpackage

// File: rtl/clkbyp_decode.sv
module clkbyp_decode
  import clkbyp_pkg::*;
(
  input  code_t                sw_ext_sel,
  input  code_t                sw_fast_sel,
  input  code_t                lc_dbg_en,
  input  code_t                lc_byp_req,
  output logic [NumLanes-1:0]  lane_en
);
  logic dbg_ok;
  logic ext_ok;

  always_comb begin
    dbg_ok = lc_is_on(lc_dbg_en);
    ext_ok = mb_is_true(sw_ext_sel) && dbg_ok;
    lane_en            = '0;
    lane_en[LANE_IO]   = lc_is_on(lc_byp_req);
    lane_en[LANE_ALL]  = ext_ok;
    lane_en[LANE_FAST] = ext_ok && mb_is_true(sw_fast_sel);
  end
endmodule

// File: rtl/clkbyp_sync.sv
module clkbyp_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= src;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clkbyp_encode.sv
module clkbyp_encode
  import clkbyp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  output code_t code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= MB_FALSE;
    else        code <= mb_encode(en);
  end
endmodule

// File: rtl/clkbyp_ctrl.sv
module clkbyp_ctrl
  import clkbyp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sw_ext_sel,
  input  logic [3:0] sw_fast_sel,
  input  logic [3:0] lc_dbg_en,
  input  logic [3:0] lc_byp_req,
  output logic [3:0] io_byp_req,
  output logic [3:0] all_byp_req,
  output logic [3:0] fast_sel
);
  // flops ahead of the output register
  localparam int PreStages = SYNC_STAGES - 1;

  logic [NumLanes-1:0] lane_en;    // decoded enables
  logic [NumLanes-1:0] lane_sync;  // after the synchronizer flops
  code_t               lane_code [NumLanes];

  clkbyp_decode u_decode (
    .sw_ext_sel  (sw_ext_sel),
    .sw_fast_sel (sw_fast_sel),
    .lc_dbg_en   (lc_dbg_en),
    .lc_byp_req  (lc_byp_req),
    .lane_en     (lane_en)
  );

  for (genvar l = 0; l < NumLanes; l++) begin : g_lane
    if (PreStages > 0) begin : g_sync
      clkbyp_sync #(.STAGES(PreStages)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lane_en[l]),
        .q     (lane_sync[l])
      );
    end else begin : g_direct
      assign lane_sync[l] = lane_en[l];
    end
    clkbyp_encode u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (lane_sync[l]),
      .code  (lane_code[l])
    );
  end

  assign io_byp_req  = lane_code[LANE_IO];
  assign all_byp_req = lane_code[LANE_ALL];
  assign fast_sel    = lane_code[LANE_FAST];
endmodule

// File: rtl/clkbyp_ctrl_chk.sv
module clkbyp_ctrl_chk
  import clkbyp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sw_ext_sel,
  input logic [3:0] sw_fast_sel,
  input logic [3:0] lc_dbg_en,
  input logic [3:0] lc_byp_req,
  input logic [3:0] io_byp_req,
  input logic [3:0] all_byp_req,
  input logic [3:0] fast_sel
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm <= '0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  logic io_want, all_want, fast_want;
  assign io_want   = lc_is_on(lc_byp_req);
  assign all_want  = mb_is_true(sw_ext_sel) && lc_is_on(lc_dbg_en);
  assign fast_want = all_want && mb_is_true(sw_fast_sel);

  // R7
  outputs_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_is_strict(io_byp_req) && code_is_strict(all_byp_req) && code_is_strict(fast_sel));

  // R9
  fast_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sel == MB_TRUE) |-> (all_byp_req == MB_TRUE));

  // R2
  io_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && $past(io_want, 2)) |-> (io_byp_req == MB_TRUE));

  // R3
  io_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && !$past(io_want, 2)) |-> (io_byp_req == MB_FALSE));

  // R4
  all_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2) |-> (all_byp_req == mb_encode($past(all_want, 2))));

  // R5
  fast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2) |-> (fast_sel == mb_encode($past(fast_want, 2))));

  // R8
  no_early_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && $stable(io_want) && $past(io_want) != $past(io_want, 2))
      |-> (io_byp_req == mb_encode($past(io_want, 2))));
endmodule

bind clkbyp_ctrl clkbyp_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_ext_sel  (sw_ext_sel),
  .sw_fast_sel (sw_fast_sel),
  .lc_dbg_en   (lc_dbg_en),
  .lc_byp_req  (lc_byp_req),
  .io_byp_req  (io_byp_req),
  .all_byp_req (all_byp_req),
  .fast_sel    (fast_sel)
);

// File: tb/sim_clkbyp_ctrl.sv
`timescale 1ns/1ps
module sim_clkbyp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [3:0] ext_sel = 4'h9, fst_sel = 4'h9, dbg = 4'h5, lcreq = 4'h5;
  logic [3:0] io_o, all_o, fast_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clkbyp_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .sw_ext_sel(ext_sel), .sw_fast_sel(fst_sel), .lc_dbg_en(dbg), .lc_byp_req(lcreq),
    .io_byp_req(io_o), .all_byp_req(all_o), .fast_sel(fast_o)
  );

  function automatic logic [3:0] code_of(bit on);
    if (on) return 4'h6;
    return 4'h9;
  endfunction

  // expected request bits: {fast, all, io}
  function automatic logic [2:0] model(logic [3:0] e, logic [3:0] h, logic [3:0] d, logic [3:0] l);
    bit dbg_on, ext_on;
    dbg_on = (d === 4'hA);
    ext_on = (e === 4'h6) && dbg_on;
    return {ext_on && (h === 4'h6), ext_on, (l === 4'hA)};
  endfunction

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [2:0] h0, h1;
  string t0, t1;
  int applied;

  task automatic step(logic [3:0] e, logic [3:0] h, logic [3:0] d, logic [3:0] l, string tag);
    @(negedge clk);
    chk("R7", "io strict", (io_o === 4'h6 || io_o === 4'h9) ? 4'h1 : 4'h0, 4'h1);
    chk("R7", "all strict", (all_o === 4'h6 || all_o === 4'h9) ? 4'h1 : 4'h0, 4'h1);
    chk("R7", "fast strict", (fast_o === 4'h6 || fast_o === 4'h9) ? 4'h1 : 4'h0, 4'h1);
    if (fast_o === 4'h6) chk("R9", "all when fast", all_o, 4'h6);
    if (applied >= 2) begin
      chk(t1, "io", io_o, code_of(h1[0]));
      chk(t1, "all", all_o, code_of(h1[1]));
      chk(t1, "fast", fast_o, code_of(h1[2]));
    end
    h1 = h0; t1 = t0;
    h0 = model(e, h, d, l); t0 = tag;
    ext_sel = e; fst_sel = h; dbg = d; lcreq = l;
    applied++;
  endtask

  function automatic logic [3:0] pick(logic [3:0] on_code);
    int r;
    r = $urandom % 5;
    if (r < 2) return on_code;
    if (r == 2) return 4'h9;
    return 4'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    applied = 0; h0 = '0; h1 = '0; t0 = ""; t1 = "";
    #1 rst_n = 1'b0;
    ext_sel = 4'h6; fst_sel = 4'h6; dbg = 4'hA; lcreq = 4'hA;
    repeat (3) @(negedge clk);
    // R1: outputs stay False under reset even with every input asserted
    chk("R1", "io reset", io_o, 4'h9);
    chk("R1", "all reset", all_o, 4'h9);
    chk("R1", "fast reset", fast_o, 4'h9);
    ext_sel = 4'h9; fst_sel = 4'h9; dbg = 4'h5; lcreq = 4'h5;
    @(negedge clk);
    rst_n = 1'b1;

    repeat (3) step(4'h9, 4'h9, 4'h5, 4'h5, "R3");
    // R8 / R2: assert lc request; one edge later still False, two edges later True
    step(4'h9, 4'h9, 4'h5, 4'hA, "R2");
    @(negedge clk);
    chk("R8", "io one edge after", io_o, 4'h9);
    h1 = h0; t1 = t0; h0 = model(ext_sel, fst_sel, dbg, lcreq); t0 = "R8"; applied++;
    step(4'h9, 4'h9, 4'h5, 4'hA, "R2");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R3");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R3");
    // R4 / R5 directed
    step(4'h6, 4'h9, 4'hA, 4'h5, "R4");
    step(4'h6, 4'h6, 4'hA, 4'h5, "R5");
    step(4'h6, 4'h6, 4'hA, 4'hA, "R5");
    step(4'h9, 4'h6, 4'hA, 4'h5, "R4");
    // R6 invalid codes
    step(4'h6, 4'h6, 4'h5, 4'hF, "R6");
    step(4'hF, 4'h6, 4'hA, 4'h0, "R6");
    step(4'h6, 4'h7, 4'hA, 4'hB, "R6");
    step(4'h2, 4'h6, 4'hB, 4'h9, "R6");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R6");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R6");
    // random mix
    for (int i = 0; i < 400; i++)
      step(pick(4'h6), pick(4'h6), pick(4'hA), pick(4'hA), "R4/R5 random");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R3");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R3");
    step(4'h9, 4'h9, 4'h5, 4'h5, "R3");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule